// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides its input clock by a programmable integer from 1 to 8. It produces a one-cycle clock enable at the start of each output period and a divided clock level. Several copies on different devices receive a common external alignment pulse. A valid pulse returns every copy's counter to the same starting state, so all copies begin their output periods on the same input clock edge. Their sampling instants therefore match.

A small control word is loaded with a single-cycle write strobe. It holds the divide ratio, an alignment enable bit and a mode bit. The mode bit selects continuous alignment, where every valid pulse realigns the counter. It can instead select one-shot alignment, where only the first valid pulse after a write realigns it. The alignment pulse comes from outside the clock domain. It is passed through a two-flop synchronizer, and only its rising edge counts as an event. A status output shows that a one-shot alignment has been used.

Top module: `sync_clk_divider`

## Requirements
- R1: The divide ratio N is written as N-1 into control bits [5:3] (ratio field), so any N from 1 to 8 can be selected. `clk_en` is high for exactly one input cycle in every N cycles.
- R2: `div_clk` is high for ceil(N/2) cycles and low for the rest of each period. Its high phase starts in the cycle where `clk_en` is high. For N=1, `div_clk` stays high and `clk_en` is high in every cycle.
- R3: After reset the counter is at zero, N is 1, alignment is disabled, one-shot mode is not armed and `sync_used` is low. As a result `clk_en` and `div_clk` are both high.
- R4: A valid alignment event forces the counter to zero. If `sync_in` is first sampled high at clock edge k, the counter is zero after edge k+2, and `clk_en` and `div_clk` are high in the cycle that follows that edge.
- R5: Only a rising edge of the synchronized `sync_in` is an event. Holding `sync_in` high for many cycles realigns the counter once.
- R6: When control bit 1 (alignment enable) is 0, every alignment pulse is ignored and the output phase continues unchanged.
- R7: When bit 1 is 1 and bit 2 (one-shot select) is 0, every event realigns the counter.
- R8: When bits 1 and 2 are both 1, only the first event after a control write realigns the counter. Later events are ignored until the next write.
- R9: A new ratio takes effect at the next counter wrap or at the next valid event, whichever comes first. The period in progress keeps the old ratio.
- R10: `sync_used` goes high one cycle after a one-shot event realigns the counter. It returns low on the cycle after the next control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Single-cycle write strobe for the control word |
| cfg_wdata | input | 5 | Control bits [5:1]: bit 1 alignment enable, bit 2 one-shot select, bits [5:3] ratio minus one |
| sync_in | input | 1 | Asynchronous alignment pulse |
| clk_en | output | 1 | One-cycle enable at the start of each output period |
| div_clk | output | 1 | Divided clock level |
| sync_used | output | 1 | A one-shot alignment has been consumed since the last write |

## Verification
Every ratio from 1 to 8 is swept after an alignment pulse, and each output is compared cycle by cycle against a phase computed from the ratio. This separates errors in period length, in the split between high and low phases, and in the divide-by-1 special case. Pulses are also applied in the middle of a period, held high for several cycles, sent while alignment is disabled, and repeated in one-shot mode before and after a rewrite. These patterns tell a realignment apart from a phase that simply continues, and an edge-triggered event apart from a level-triggered one. A ratio written in the middle of a long period shows whether the change waits for the wrap.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // number of high cycles for a period whose terminal count is cmax (N = cmax+1)
  function automatic logic [31:0] high_len(input logic [31:0] cmax);
    return (cmax + 32'd2) >> 1;
  endfunction

  // a sync event is honoured when enabled, and in one-shot mode only while armed
  function automatic logic sync_accept(input logic evt, input logic en,
                                       input logic oneshot, input logic armed);
    return evt & en & (~oneshot | armed);
  endfunction

endpackage

// File: rtl/clkdiv_sync_edge.sv
module clkdiv_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic evt_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  // rising edge of the last synchronizer stage
  assign evt_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic en_i,
  input  logic oneshot_i,
  input  logic cfg_we_i,
  output logic valid_o,
  output logic armed_o,
  output logic used_o
);
  import clkdiv_pkg::*;

  logic armed_q, used_q;

  assign valid_o = sync_accept(evt_i, en_i, oneshot_i, armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      used_q  <= 1'b0;
    end else if (cfg_we_i) begin
      armed_q <= 1'b1;
      used_q  <= 1'b0;
    end else if (valid_o && oneshot_i) begin
      armed_q <= 1'b0;
      used_q  <= 1'b1;
    end
  end

  assign armed_o = armed_q;
  assign used_o  = used_q;
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic [RATIO_W-1:0] cfg_max_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] act_max_o,
  output logic               wrap_o,
  output logic               clk_en_o,
  output logic               div_clk_o
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] cnt_q, act_q;

  assign wrap_o = (cnt_q == act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (restart_i || wrap_o) begin
      cnt_q <= '0;
      act_q <= cfg_max_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_en_o  = (cnt_q == '0);
  assign div_clk_o = (32'(cnt_q) < high_len(32'(act_q)));
  assign cnt_o     = cnt_q;
  assign act_max_o = act_q;
endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider #(
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int EN_BIT     = 1,
  localparam int OS_BIT     = 2,
  localparam int RATIO_LSB  = 3,
  localparam int CFG_MSB    = RATIO_LSB + RATIO_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_MSB:1]   cfg_wdata,
  input  logic               sync_in,
  output logic               clk_en,
  output logic               div_clk,
  output logic               sync_used
);
  logic               sync_en_q, oneshot_q;
  logic [RATIO_W-1:0] cfg_max_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_en_q <= 1'b0;
      oneshot_q <= 1'b0;
      cfg_max_q <= '0;
    end else if (cfg_we) begin
      sync_en_q <= cfg_wdata[EN_BIT];
      oneshot_q <= cfg_wdata[OS_BIT];
      cfg_max_q <= cfg_wdata[CFG_MSB:RATIO_LSB];
    end
  end

  // named internal events for the checker
  logic               sync_evt, sync_valid, sync_armed, cnt_wrap;
  logic [RATIO_W-1:0] cnt_val, act_max;

  clkdiv_sync_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_n), .async_i(sync_in), .evt_o(sync_evt)
  );

  clkdiv_gate gate_i (
    .clk(clk), .rst_n(rst_n), .evt_i(sync_evt), .en_i(sync_en_q),
    .oneshot_i(oneshot_q), .cfg_we_i(cfg_we), .valid_o(sync_valid),
    .armed_o(sync_armed), .used_o(sync_used)
  );

  clkdiv_counter #(.RATIO_W(RATIO_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .restart_i(sync_valid), .cfg_max_i(cfg_max_q),
    .cnt_o(cnt_val), .act_max_o(act_max), .wrap_o(cnt_wrap),
    .clk_en_o(clk_en), .div_clk_o(div_clk)
  );
endmodule

// File: rtl/sync_clk_divider_chk.sv
module sync_clk_divider_chk #(
  parameter int RATIO_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               sync_valid,
  input logic               sync_en_q,
  input logic               oneshot_q,
  input logic               sync_armed,
  input logic               sync_used,
  input logic               clk_en,
  input logic               div_clk,
  input logic [RATIO_W-1:0] cnt_val,
  input logic [RATIO_W-1:0] act_max
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_val <= act_max); // R1

  AST_EN_IMPLIES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> div_clk); // R2

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> (clk_en && div_clk)); // R4

  AST_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en_q |-> !sync_valid); // R6

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && oneshot_q && !cfg_we) |=> (!sync_armed && sync_used)); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !sync_used); // R10
endmodule

bind sync_clk_divider sync_clk_divider_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .sync_valid(sync_valid),
  .sync_en_q(sync_en_q), .oneshot_q(oneshot_q), .sync_armed(sync_armed),
  .sync_used(sync_used), .clk_en(clk_en), .div_clk(div_clk),
  .cnt_val(cnt_val), .act_max(act_max)
);

// File: tb/sync_clk_divider_tb.sv
`timescale 1ns/1ps
module sync_clk_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:1] cfg_wdata = '0;
  logic       sync_in = 1'b0;
  logic       clk_en, div_clk, sync_used;

  always #10 clk = ~clk;

  sync_clk_divider dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sync_in(sync_in), .clk_en(clk_en), .div_clk(div_clk), .sync_used(sync_used)
  );

  int    total = 0, bad = 0;
  bit    finished = 0;
  int    ph = 0, n_act = 1, n_pend = 1;
  bit    exp_used = 0, os_mode = 0;
  string tag = "R3";

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (phase %0d of %0d)",
               tag, what, act, exp, ph, n_act);
    end
  endtask

  // compare outputs against the bench phase model, then advance one cycle
  task automatic tick();
    chk("clk_en", int'(clk_en), int'(ph == 0));
    chk("div_clk", int'(div_clk), int'(ph < (n_act + 1) / 2));
    chk("sync_used", int'(sync_used), int'(exp_used));
    @(negedge clk);
    if (ph == n_act - 1) begin ph = 0; n_act = n_pend; end
    else ph++;
  endtask

  task automatic wcfg(input int ratio, input bit en, input bit os);
    cfg_we = 1'b1;
    cfg_wdata = {3'(ratio - 1), os, en};
    tick();
    cfg_we = 1'b0;
    n_pend = ratio;
    os_mode = os;
    exp_used = 0;
  endtask

  // raise sync_in for 'hold' cycles; realignment expected after edge k+2 if valid
  task automatic do_sync(input int hold, input bit valid);
    int span = (hold > 3) ? hold : 3;
    sync_in = 1'b1;
    for (int t = 0; t < span; t++) begin
      if (t == hold) sync_in = 1'b0;
      tick();
      if (t == 2 && valid) begin
        ph = 0; n_act = n_pend;
        if (os_mode) exp_used = 1;
      end
    end
    sync_in = 1'b0;
    tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset state, ratio 1 with both outputs high
    tag = "R3";
    repeat (4) tick();

    // R1 R2: sweep every ratio after an aligning pulse
    for (int n = 1; n <= 8; n++) begin
      tag = "R1_R2_R4";
      wcfg(n, 1'b1, 1'b0);
      do_sync(1, 1'b1);
      repeat (3 * n) tick();
    end

    // R9: ratio change mid-period waits for the wrap
    tag = "R9";
    wcfg(8, 1'b1, 1'b0);
    do_sync(1, 1'b1);
    repeat (2) tick();
    wcfg(3, 1'b1, 1'b0);
    repeat (20) tick();
    // R9: new ratio applied by a valid pulse before the wrap
    wcfg(7, 1'b1, 1'b0);
    do_sync(1, 1'b1);
    repeat (2) tick();
    wcfg(2, 1'b1, 1'b0);
    do_sync(1, 1'b1);
    repeat (6) tick();

    // R5: a held-high pulse realigns only once
    tag = "R5";
    wcfg(5, 1'b1, 1'b0);
    do_sync(1, 1'b1);
    repeat (2) tick();
    do_sync(9, 1'b1);
    repeat (12) tick();

    // R7: continuous mode realigns on every pulse, flag stays low
    tag = "R7";
    wcfg(4, 1'b1, 1'b0);
    do_sync(1, 1'b1);
    tick();
    do_sync(2, 1'b1);
    repeat (2) tick();
    do_sync(1, 1'b1);
    repeat (8) tick();

    // R6: alignment disabled, phase continues
    tag = "R6";
    wcfg(6, 1'b1, 1'b0);
    do_sync(1, 1'b1);
    repeat (2) tick();
    wcfg(6, 1'b0, 1'b0);
    tick();
    do_sync(1, 1'b0);
    repeat (5) tick();
    do_sync(4, 1'b0);
    repeat (8) tick();

    // R8 R10: one-shot consumed once, rearmed by a write
    tag = "R8_R10";
    wcfg(5, 1'b1, 1'b1);
    tick();
    do_sync(1, 1'b1);
    repeat (2) tick();
    do_sync(1, 1'b0);
    repeat (3) tick();
    do_sync(2, 1'b0);
    repeat (4) tick();
    wcfg(5, 1'b1, 1'b1);
    repeat (3) tick();
    do_sync(1, 1'b1);
    repeat (7) tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule